// File: doc/BRIEF.md
# ADC Interrupt Flag Controller

This block keeps the six interrupt status flags of an analog-to-digital converter's control logic. The conversion sequencer sends it single-cycle strobes: a start trigger (together with a level that says a conversion is in progress), a sample-stored strobe, a result-stored strobe that marks the end of a conversion or accumulation, and a window-match level. Software reaches the flags through a write strobe with write-one-to-clear data. It also sends read strobes for the sample and result data registers.

Two small state machines, one for the sample register and one for the result register, record whether the stored value has been read. Each has two states, `UNREAD_EMPTY` and `UNREAD_HELD`. A store with no read in the same cycle moves it to `UNREAD_HELD`. A read with no store moves it to `UNREAD_EMPTY`. A store and a read in the same cycle leave it in `UNREAD_HELD`. A store that arrives in `UNREAD_HELD` with no read in that cycle is an overwrite.

The flags form a byte with two upper bits that always read zero. A registered interrupt request is raised when any flag is set whose bit in a 6-bit enable mask is also set.

Top module: `adc_irq_flags`

## Requirements
- R1: After reset `flag_byte` is 0x00 and `irq` is 0. Bits 7 and 6 of `flag_byte` are always 0.
- R2: A cycle with `flag_wr` high clears every flag whose bit in `flag_wdata` is 1. Flags whose bit is 0 are left unchanged. The bit positions are: 0 result-ready, 1 sample-ready, 2 window-compare, 3 result-overwrite, 4 sample-overwrite, 5 trigger-overrun.
- R3: Trigger-overrun (bit 5) is set in the cycle after `evt_trigger` arrives while `conv_busy` is high. A trigger while `conv_busy` is low sets nothing.
- R4: Sample-ready (bit 1) is set in the cycle after `evt_sample_done`. It is cleared by a write of 1 to bit 1 or by `sample_rd`.
- R5: Result-ready (bit 0) is set in the cycle after `evt_result_done`. It is cleared by a write of 1 to bit 0 or by `result_rd`.
- R6: Window-compare (bit 2) is set only by `evt_result_done` with `win_match` high. `win_match` alone, or a result without it, leaves bit 2 at 0.
- R7: Sample-overwrite (bit 4) is set when `evt_sample_done` arrives while the previous sample is unread and `sample_rd` is low in that cycle. Clearing sample-ready by a write does not mark the sample as read.
- R8: Result-overwrite (bit 3) is set when `evt_result_done` arrives while the previous result is unread and `result_rd` is low in that cycle.
- R9: If a flag's set event and its clear (a write of 1 or a register read) fall in the same cycle, the flag ends up set.
- R10: `irq` is registered. In each cycle it equals the OR over the six bits of the previous cycle's flags ANDed with the previous cycle's `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_trigger | input | 1 | Start-trigger strobe |
| conv_busy | input | 1 | High while a conversion is in progress |
| evt_sample_done | input | 1 | New sample stored |
| evt_result_done | input | 1 | Conversion or accumulation complete, new result stored |
| win_match | input | 1 | Window condition met for the selected source and mode |
| flag_wr | input | 1 | Write strobe for the flag register |
| flag_wdata | input | 6 | Write-one-to-clear data for flag bits 5..0 |
| sample_rd | input | 1 | Read strobe of the sample register |
| result_rd | input | 1 | Read strobe of the result register |
| irq_en | input | 6 | Interrupt enable mask, one bit per flag |
| flag_byte | output | 8 | Flag byte, bits 7..6 always zero |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume every event and read input is a one-cycle strobe sampled at the rising edge, with `conv_busy` and `win_match` valid in the same cycle. They also assume that no input is X once reset is released. The bench changes inputs only on falling edges, holds each strobe for exactly one cycle and returns every input to zero between scenarios. A cleanup cycle that reads both data registers and writes 1 to every flag returns both unread machines to `UNREAD_EMPTY` between scenarios, so each scenario's expected byte does not depend on the ones before it.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
    localparam int FLAG_W = 6;
    localparam int BYTE_W = 8;
    localparam int PAD_W  = BYTE_W - FLAG_W;

    // flag bit positions (software decodes these)
    localparam int F_RES_RDY  = 0;
    localparam int F_SAMP_RDY = 1;
    localparam int F_WIN      = 2;
    localparam int F_RES_OVR  = 3;
    localparam int F_SAMP_OVR = 4;
    localparam int F_TRIG_OVR = 5;

    typedef enum logic {
        UNREAD_EMPTY = 1'b0,
        UNREAD_HELD  = 1'b1
    } unread_state_t;
endpackage

// File: rtl/adc_unread_fsm.sv
module adc_unread_fsm
    import adc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic store,
    input  logic rd,
    output logic overwrite
);
    unread_state_t st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= UNREAD_EMPTY;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UNREAD_EMPTY: if (store)        st_d = UNREAD_HELD;
            UNREAD_HELD:  if (rd && !store) st_d = UNREAD_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        overwrite = 1'b0;
        unique case (st_q)
            UNREAD_EMPTY: overwrite = 1'b0;
            UNREAD_HELD:  overwrite = store && !rd;
        endcase
    end
endmodule

// File: rtl/adc_flag_bank.sv
module adc_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (set_i[i]) bit_q <= 1'b1;   // set beats clear
            else if (clr_i[i]) bit_q <= 1'b0;
        end
        assign flag_o[i] = bit_q;
    end
endmodule

// File: rtl/adc_irq_gate.sv
module adc_irq_gate #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(flag_i & en_i);
    end
endmodule

// File: rtl/adc_irq_flags.sv
module adc_irq_flags
    import adc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_trigger,
    input  logic              conv_busy,
    input  logic              evt_sample_done,
    input  logic              evt_result_done,
    input  logic              win_match,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flag_wdata,
    input  logic              sample_rd,
    input  logic              result_rd,
    input  logic [FLAG_W-1:0] irq_en,
    output logic [BYTE_W-1:0] flag_byte,
    output logic              irq
);
    logic [FLAG_W-1:0] set_v, clr_v, flags;
    logic              samp_ovr, res_ovr;

    adc_unread_fsm u_samp_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (evt_sample_done),
        .rd        (sample_rd),
        .overwrite (samp_ovr)
    );

    adc_unread_fsm u_res_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (evt_result_done),
        .rd        (result_rd),
        .overwrite (res_ovr)
    );

    always_comb begin
        set_v             = '0;
        set_v[F_RES_RDY]  = evt_result_done;
        set_v[F_SAMP_RDY] = evt_sample_done;
        set_v[F_WIN]      = evt_result_done && win_match;
        set_v[F_RES_OVR]  = res_ovr;
        set_v[F_SAMP_OVR] = samp_ovr;
        set_v[F_TRIG_OVR] = evt_trigger && conv_busy;

        clr_v             = flag_wr ? flag_wdata : '0;
        clr_v[F_RES_RDY]  = clr_v[F_RES_RDY]  | result_rd;
        clr_v[F_SAMP_RDY] = clr_v[F_SAMP_RDY] | sample_rd;
    end

    adc_flag_bank #(.N(FLAG_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .flag_o (flags)
    );

    adc_irq_gate #(.N(FLAG_W)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .flag_i(flags),
        .en_i  (irq_en),
        .irq_o (irq)
    );

    assign flag_byte = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/adc_irq_flags_chk.sv
module adc_irq_flags_chk
    import adc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              evt_trigger,
    input logic              conv_busy,
    input logic              evt_sample_done,
    input logic              evt_result_done,
    input logic              win_match,
    input logic              flag_wr,
    input logic [FLAG_W-1:0] flag_wdata,
    input logic              sample_rd,
    input logic              result_rd,
    input logic [FLAG_W-1:0] irq_en,
    input logic [BYTE_W-1:0] flag_byte,
    input logic              irq
);
    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_byte[BYTE_W-1:FLAG_W] == '0);

    // R2
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr && flag_wdata[F_TRIG_OVR] && !(evt_trigger && conv_busy)
        |=> !flag_byte[F_TRIG_OVR]);

    // R3
    trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trigger && conv_busy |=> flag_byte[F_TRIG_OVR]);

    // R4
    samp_rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sample_done |=> flag_byte[F_SAMP_RDY]);

    // R4
    samp_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_rd && !evt_sample_done |=> !flag_byte[F_SAMP_RDY]);

    // R5
    res_rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_result_done |=> flag_byte[F_RES_RDY]);

    // R5
    res_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_rd && !evt_result_done |=> !flag_byte[F_RES_RDY]);

    // R6
    win_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_byte[F_WIN]) |-> $past(evt_result_done && win_match));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(flag_byte[FLAG_W-1:0] & irq_en)));
endmodule

bind adc_irq_flags adc_irq_flags_chk u_chk (.*);

// File: tb/adc_irq_flags_tb.sv
`timescale 1ns/1ps
module adc_irq_flags_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_trigger = 0, conv_busy = 0, evt_sample_done = 0;
    logic       evt_result_done = 0, win_match = 0, flag_wr = 0;
    logic [5:0] flag_wdata = '0;
    logic       sample_rd = 0, result_rd = 0;
    logic [5:0] irq_en = '0;
    logic [7:0] flag_byte;
    logic       irq;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_irq_flags u_dut (
        .clk(clk), .rst_n(rst_n), .evt_trigger(evt_trigger), .conv_busy(conv_busy),
        .evt_sample_done(evt_sample_done), .evt_result_done(evt_result_done),
        .win_match(win_match), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .sample_rd(sample_rd), .result_rd(result_rd), .irq_en(irq_en),
        .flag_byte(flag_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        evt_trigger = 0; conv_busy = 0; evt_sample_done = 0; evt_result_done = 0;
        win_match = 0; flag_wr = 0; flag_wdata = '0; sample_rd = 0; result_rd = 0;
    endtask

    // inputs already set at a falling edge; hold one cycle, then release
    task automatic cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic clean();
        @(negedge clk);
        sample_rd = 1; result_rd = 1; flag_wr = 1; flag_wdata = 6'h3F;
        cycle();
    endtask

    task automatic t_reset();
        chk("R1 reset flags", flag_byte, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_trigger();
        evt_trigger = 1; conv_busy = 0; cycle();
        chk("R3 idle trigger", flag_byte, 8'h00);
        evt_trigger = 1; conv_busy = 1; cycle();
        chk("R3 busy trigger", flag_byte, 8'h20);
        flag_wr = 1; flag_wdata = 6'h1F; cycle();
        chk("R2 write zero keeps", flag_byte, 8'h20);
        flag_wr = 1; flag_wdata = 6'h20; cycle();
        chk("R2 write one clears", flag_byte, 8'h00);
    endtask

    task automatic t_sample();
        clean();
        evt_sample_done = 1; cycle();
        chk("R4 sample ready set", flag_byte, 8'h02);
        sample_rd = 1; cycle();
        chk("R4 read clears", flag_byte, 8'h00);
        evt_sample_done = 1; cycle();
        flag_wr = 1; flag_wdata = 6'h02; cycle();
        chk("R4 R2 write clears sample ready", flag_byte, 8'h00);
        evt_sample_done = 1; cycle();
        chk("R7 write clear is not a read", flag_byte, 8'h12);
    endtask

    task automatic t_result_window();
        clean();
        evt_result_done = 1; cycle();
        chk("R5 R6 result ready no window", flag_byte, 8'h01);
        result_rd = 1; cycle();
        chk("R5 read clears", flag_byte, 8'h00);
        win_match = 1; cycle();
        chk("R6 match alone", flag_byte, 8'h00);
        evt_result_done = 1; win_match = 1; cycle();
        chk("R6 window set", flag_byte, 8'h05);
    endtask

    task automatic t_overwrites();
        clean();
        evt_result_done = 1; cycle();
        evt_result_done = 1; cycle();
        chk("R8 result overwrite", flag_byte, 8'h09);
        clean();
        evt_result_done = 1; cycle();
        result_rd = 1; cycle();
        evt_result_done = 1; cycle();
        chk("R8 read between", flag_byte, 8'h01);
        clean();
        evt_result_done = 1; cycle();
        evt_result_done = 1; result_rd = 1; cycle();
        chk("R8 R9 same-cycle read", flag_byte, 8'h01);
        clean();
        evt_sample_done = 1; cycle();
        evt_sample_done = 1; cycle();
        chk("R7 sample overwrite", flag_byte, 8'h12);
        clean();
        evt_sample_done = 1; cycle();
        evt_sample_done = 1; sample_rd = 1; cycle();
        chk("R7 R9 same-cycle read", flag_byte, 8'h02);
    endtask

    task automatic t_priority();
        clean();
        evt_trigger = 1; conv_busy = 1; flag_wr = 1; flag_wdata = 6'h20; cycle();
        chk("R9 trigger set beats clear", flag_byte, 8'h20);
        clean();
        evt_sample_done = 1; flag_wr = 1; flag_wdata = 6'h3F; cycle();
        chk("R9 sample set beats clear", flag_byte, 8'h02);
    endtask

    task automatic t_irq();
        clean();
        irq_en = 6'h3F;
        @(negedge clk);
        evt_result_done = 1; cycle();
        chk("R10 irq one cycle late", {7'b0, irq}, 8'h00);
        @(negedge clk);
        chk("R10 irq raised", {7'b0, irq}, 8'h01);
        clean();
        irq_en = 6'h01;
        @(negedge clk);
        evt_sample_done = 1; cycle();
        @(negedge clk);
        chk("R10 masked", {7'b0, irq}, 8'h00);
        irq_en = 6'h02;
        @(negedge clk);
        chk("R10 enable opens", {7'b0, irq}, 8'h01);
        clean();
        @(negedge clk);
        chk("R10 cleared", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_trigger();
        t_sample();
        t_result_window();
        t_overwrites();
        t_priority();
        t_irq();
        chk("R1 upper bits", {flag_byte[7:6], 6'b0}, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule